// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Controller

This peripheral sits between a 32-bit memory-mapped host port and a word-wide configuration port. A local word buffer, mapped at the bottom of the address space, is read and written by the host like ordinary memory. Three control registers sit above the buffer and set a transfer length in bytes and a starting buffer word. A write to a fourth register starts the transfer. Configure moves words from the buffer out to the port. Readback moves words from the port into the buffer.

The host fills the buffer, programs length and start word, and writes the direction register. It then polls the done bit of the status word. The status word also carries four flags taken directly from the port. A write to the status address stops any transfer and returns the sequencer to idle. On the port side a configure word is handed over with a write strobe and held while the port signals busy. A readback runs under a read request, and the port marks each word it returns with a valid pulse.

Top module: `cfx_xfer_ctrl`

## Requirements
- R1: Buffer word N (0..511) is read and written at byte address N*4 (address bit 11 = 0). Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: Byte address 0x800 holds the 32-bit length register and 0x804 holds the start-word register. Both are readable and writable. The start-word register keeps 9 bits and reads back zero-extended.
- R3: Reading 0x80C returns the status word. Bit 0 is done, bits 4..1 read 1, bit 5 is `cp_abort_n`, bit 6 is `cp_rd_active`, bit 7 is `cp_aligned`, bit 8 is `cp_cfg_err`, and all other bits read 0. Done is 1 after reset.
- R4: Writing 0x808 with bit 0 = 0 starts a configure. Length/4 words are sent, starting at the start word. One word is accepted on each clock edge where `cp_wr_en` is high and `cp_busy` is low. `cp_wdata` holds steady while busy.
- R5: Writing 0x808 with bit 0 = 1 starts a readback. `cp_rd_req` stays high until length/4 words have arrived. Each edge with `cp_rd_valid` high stores `cp_rdata` in the next buffer word. Words outside that range are not touched.
- R6: Done reads 0 from the cycle after a start. It reads 1 in the cycle after the edge that accepts the last word. No port strobe is active while done is 1.
- R7: A length below 4 (zero words) produces no port activity, and done stays 1.
- R8: Buffer addressing during a transfer wraps from word 511 to word 0.
- R9: A write to 0x808 while a transfer runs is ignored. Writes to the length or start-word register during a transfer do not change the transfer in flight.
- R10: Any write to 0x80C ends a running transfer. Done is 1 and both port strobes are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| cp_wr_en | output | 1 | Configure word offered to the port |
| cp_wdata | output | 32 | Configure word |
| cp_busy | input | 1 | Port cannot accept a word this cycle |
| cp_rd_req | output | 1 | Readback in progress, port may return words |
| cp_rd_valid | input | 1 | Port returns a word this cycle |
| cp_rdata | input | 32 | Word returned by the port |
| cp_abort_n | input | 1 | Port abort flag, active low |
| cp_rd_active | input | 1 | Port readback-in-progress flag |
| cp_aligned | input | 1 | Port data-aligned flag |
| cp_cfg_err | input | 1 | Port configuration-error flag |

## Verification
Host reads complete one cycle after the strobe, so the bench samples `bus_rdata` on the falling edge that follows the rising edge which captured the read. The start write takes effect on one rising edge. A configure with an idle port offers its first word two edges later, because the buffer read is registered, and then offers one word per edge. The bench counts `cp_wr_en` on falling edges to confirm that exactly the requested words leave back to back. The port stub samples strobes and drives busy/valid on falling edges, so every hand-off it records matches what the design saw at the next rising edge. Done is checked through status reads, which already reflect the edge that accepted the last word or the abort write.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_SEND  = 2'd2,
    SQ_PULL  = 2'd3
  } sq_state_t;

  localparam logic [1:0] REG_LEN  = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_DIR  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
endpackage

// File: rtl/cfx_wordbuf.sv
module cfx_wordbuf #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  // Both ports in one process; callers never write the same word at once.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/cfx_sequencer.sv
module cfx_sequencer
  import cfx_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = DW - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_rb,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [AW-1:0]    base_in,
  input  logic             abort,
  input  logic             cp_busy,
  input  logic             cp_rd_valid,
  input  logic [DW-1:0]    cp_rdata,
  input  logic [DW-1:0]    ram_q,
  output logic             done,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_we,
  output logic [DW-1:0]    ram_wdata,
  output logic             cp_wr_en,
  output logic [DW-1:0]    cp_wdata,
  output logic             cp_rd_req
);
  sq_state_t        state;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] remain;
  logic             step;

  assign step      = (state == SQ_SEND && !cp_busy) || (state == SQ_PULL && cp_rd_valid);
  assign ram_addr  = (state == SQ_SEND && !cp_busy) ? ptr + AW'(1) : ptr;
  assign ram_we    = (state == SQ_PULL) && cp_rd_valid;
  assign ram_wdata = cp_rdata;
  assign cp_wr_en  = (state == SQ_SEND);
  assign cp_wdata  = ram_q;
  assign cp_rd_req = (state == SQ_PULL);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state  <= SQ_IDLE;
      done   <= 1'b1;
      ptr    <= '0;
      remain <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            if (cnt_in == '0) begin
              done <= 1'b1;
            end else begin
              ptr    <= base_in;
              remain <= cnt_in;
              done   <= 1'b0;
              state  <= start_rb ? SQ_PULL : SQ_FETCH;
            end
          end
        end
        SQ_FETCH: state <= SQ_SEND;
        default: begin
          if (step) begin
            ptr    <= ptr + AW'(1);
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) begin
              state <= SQ_IDLE;
              done  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfx_xfer_ctrl.sv
module cfx_xfer_ctrl
  import cfx_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int ADDR_W = AW + 3,
  localparam int CNT_W  = DW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              cp_wr_en,
  output logic [DW-1:0]     cp_wdata,
  input  logic              cp_busy,
  output logic              cp_rd_req,
  input  logic              cp_rd_valid,
  input  logic [DW-1:0]     cp_rdata,
  input  logic              cp_abort_n,
  input  logic              cp_rd_active,
  input  logic              cp_aligned,
  input  logic              cp_cfg_err
);
  logic          in_regs;
  logic [1:0]    reg_sel;
  logic          buf_we;
  logic [DW-1:0] len_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] reg_rd_q;
  logic          rd_buf_d;
  logic [DW-1:0] host_q;
  logic          seq_done;
  logic          start;
  logic          abort;
  logic [AW-1:0] sq_addr;
  logic          sq_we;
  logic [DW-1:0] sq_wdata;
  logic [DW-1:0] sq_q;
  logic [DW-1:0] status_word;

  assign in_regs = bus_addr[ADDR_W-1];
  assign reg_sel = bus_addr[3:2];
  assign buf_we  = bus_wr && !in_regs;
  assign start   = bus_wr && in_regs && reg_sel == REG_DIR;
  assign abort   = bus_wr && in_regs && reg_sel == REG_STAT;

  always_comb begin
    status_word      = '0;
    status_word[0]   = seq_done;
    status_word[4:1] = 4'hF;
    status_word[5]   = cp_abort_n;
    status_word[6]   = cp_rd_active;
    status_word[7]   = cp_aligned;
    status_word[8]   = cp_cfg_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      base_q   <= '0;
      reg_rd_q <= '0;
      rd_buf_d <= 1'b0;
    end else begin
      if (bus_wr && in_regs && reg_sel == REG_LEN)  len_q  <= bus_wdata;
      if (bus_wr && in_regs && reg_sel == REG_BASE) base_q <= bus_wdata[AW-1:0];
      if (bus_rd) begin
        rd_buf_d <= !in_regs;
        case (reg_sel)
          REG_LEN:  reg_rd_q <= len_q;
          REG_BASE: reg_rd_q <= DW'(base_q);
          REG_STAT: reg_rd_q <= status_word;
          default:  reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_buf_d ? host_q : reg_rd_q;

  cfx_wordbuf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk     (clk),
    .a_we    (buf_we),
    .a_addr  (bus_addr[AW+1:2]),
    .a_wdata (bus_wdata),
    .a_q     (host_q),
    .b_we    (sq_we),
    .b_addr  (sq_addr),
    .b_wdata (sq_wdata),
    .b_q     (sq_q)
  );

  cfx_sequencer #(.DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_rb    (bus_wdata[0]),
    .cnt_in      (len_q[DW-1:2]),
    .base_in     (base_q),
    .abort       (abort),
    .cp_busy     (cp_busy),
    .cp_rd_valid (cp_rd_valid),
    .cp_rdata    (cp_rdata),
    .ram_q       (sq_q),
    .done        (seq_done),
    .ram_addr    (sq_addr),
    .ram_we      (sq_we),
    .ram_wdata   (sq_wdata),
    .cp_wr_en    (cp_wr_en),
    .cp_wdata    (cp_wdata),
    .cp_rd_req   (cp_rd_req)
  );
endmodule

// File: rtl/cfx_checker.sv
module cfx_checker #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cp_wr_en,
  input logic              cp_busy,
  input logic [DW-1:0]     cp_wdata,
  input logic              cp_rd_req,
  input logic              done
);
  logic stat_wr;
  assign stat_wr = bus_wr && bus_addr[ADDR_W-1] && bus_addr[3:2] == 2'd3;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cp_wr_en && cp_rd_req)); // R5

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cp_wr_en && cp_busy && !stat_wr) |=> (cp_wr_en && $stable(cp_wdata))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cp_wr_en && !cp_rd_req)); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (done && !cp_wr_en && !cp_rd_req)); // R10
endmodule

bind cfx_xfer_ctrl cfx_checker #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cp_wr_en  (cp_wr_en),
  .cp_busy   (cp_busy),
  .cp_wdata  (cp_wdata),
  .cp_rd_req (cp_rd_req),
  .done      (seq_done)
);

// File: tb/tb_cfx_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_cfx_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cp_wr_en, cp_rd_req;
  logic [31:0] cp_wdata;
  logic        cp_busy = 1'b0, cp_rd_valid = 1'b0;
  logic [31:0] cp_rdata = '0;
  logic        cp_abort_n = 1'b1, cp_rd_active = 1'b0, cp_aligned = 1'b0, cp_cfg_err = 1'b0;

  int total = 0, bad = 0;
  int cyc = 0, cap_n = 0, rb_idx = 0;
  int busy_mode = 0, rb_mode = 0;
  logic [31:0] cap [32];

  always #5 clk = ~clk;

  cfx_xfer_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_wr_en(cp_wr_en), .cp_wdata(cp_wdata),
    .cp_busy(cp_busy), .cp_rd_req(cp_rd_req), .cp_rd_valid(cp_rd_valid), .cp_rdata(cp_rdata),
    .cp_abort_n(cp_abort_n), .cp_rd_active(cp_rd_active), .cp_aligned(cp_aligned),
    .cp_cfg_err(cp_cfg_err)
  );

  // Port stub: samples hand-offs, then drives busy/valid for the next edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst && cp_wr_en && !cp_busy) begin
      if (cap_n < 32) cap[cap_n] = cp_wdata;
      cap_n = cap_n + 1;
    end
    cp_busy = (busy_mode == 1) ? (cyc % 3 == 1) : 1'b0;
    if (!rst && cp_rd_req && (rb_mode == 1 || (rb_mode == 2 && cyc % 2 == 0))) begin
      cp_rd_valid = 1'b1;
      cp_rdata    = 32'hA000_0000 + rb_idx;
      rb_idx      = rb_idx + 1;
    end else begin
      cp_rd_valid = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 500; i++) begin
      bus_read(12'h80C, s);
      if (s[0]) break;
    end
    chk(req, {31'b0, s[0]}, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(12'h80C, d);
    chk("R3 reset status", d, 32'h0000_003F);
    cp_abort_n = 1'b0; cp_rd_active = 1'b1; cp_aligned = 1'b0; cp_cfg_err = 1'b1;
    bus_read(12'h80C, d);
    chk("R3 flag positions", d, 32'h0000_015F);
    cp_abort_n = 1'b1; cp_rd_active = 1'b0; cp_aligned = 1'b1; cp_cfg_err = 1'b0;
    bus_read(12'h80C, d);
    chk("R3 flag positions 2", d, 32'h0000_00BF);
    cp_aligned = 1'b0;
  endtask

  task automatic t_buffer;
    logic [31:0] d;
    bus_write(12'h000, 32'h1111_0000);
    bus_write(12'h004, 32'h2222_0001);
    bus_write(12'h7FC, 32'h3333_01FF);
    bus_read(12'h004, d); chk("R1 word 1", d, 32'h2222_0001);
    bus_read(12'h000, d); chk("R1 word 0", d, 32'h1111_0000);
    bus_read(12'h7FC, d); chk("R1 word 511", d, 32'h3333_01FF);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(12'h800, 32'h0000_0123);
    bus_write(12'h804, 32'hFFFF_FE05);
    bus_read(12'h800, d); chk("R2 length readback", d, 32'h0000_0123);
    bus_read(12'h804, d); chk("R2 start word readback", d, 32'h0000_0005);
  endtask

  task automatic t_config_busy;
    logic [31:0] d;
    for (int k = 0; k < 6; k++) bus_write(12'((10 + k) * 4), 32'hC0DE_0000 + k);
    busy_mode = 1; cap_n = 0;
    bus_write(12'h800, 32'd24);
    bus_write(12'h804, 32'd10);
    bus_write(12'h808, 32'd0);
    bus_read(12'h80C, d); chk("R6 done low after start", {31'b0, d[0]}, 32'h0);
    bus_write(12'h800, 32'd4);      // R9: must not shorten the burst
    bus_write(12'h804, 32'd0);      // R9: must not move the burst
    bus_write(12'h808, 32'd1);      // R9: restart attempt ignored
    wait_done("R4 configure completes");
    chk("R4 R9 word count", 32'(cap_n), 32'd6);
    for (int k = 0; k < 6; k++) chk("R4 configure word order", cap[k], 32'hC0DE_0000 + k);
    bus_read(12'h800, d); chk("R2 length written mid-transfer", d, 32'd4);
    busy_mode = 0;
  endtask

  task automatic t_config_rate;
    int hi;
    logic [31:0] d;
    hi = 0; cap_n = 0;
    for (int k = 0; k < 3; k++) bus_write(12'(k * 4), 32'h5A00_0000 + k);
    bus_write(12'h800, 32'd12);
    bus_write(12'h804, 32'd0);
    bus_write(12'h808, 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cp_wr_en) hi++;
    end
    chk("R4 one word per idle cycle", 32'(hi), 32'd3);
    chk("R4 words accepted", 32'(cap_n), 32'd3);
    bus_read(12'h80C, d); chk("R6 done after last word", {31'b0, d[0]}, 32'h1);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    bus_write(12'(99 * 4), 32'hDEAD_0099);
    bus_write(12'(105 * 4), 32'hDEAD_0105);
    rb_mode = 2; rb_idx = 0;
    bus_write(12'h800, 32'd20);
    bus_write(12'h804, 32'd100);
    bus_write(12'h808, 32'd1);
    wait_done("R5 readback completes");
    rb_mode = 0;
    for (int k = 0; k < 5; k++) begin
      bus_read(12'((100 + k) * 4), d);
      chk("R5 readback word", d, 32'hA000_0000 + k);
    end
    bus_read(12'(99 * 4), d);  chk("R5 word before range kept", d, 32'hDEAD_0099);
    bus_read(12'(105 * 4), d); chk("R5 word after range kept", d, 32'hDEAD_0105);
  endtask

  task automatic t_zero;
    int act;
    logic [31:0] d;
    act = 0;
    bus_write(12'h800, 32'd3);
    bus_write(12'h808, 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cp_wr_en || cp_rd_req) act++;
    end
    chk("R7 no port activity", 32'(act), 32'd0);
    bus_read(12'h80C, d); chk("R7 done stays set", {31'b0, d[0]}, 32'h1);
  endtask

  task automatic t_wrap;
    bus_write(12'(510 * 4), 32'hE000_0000);
    bus_write(12'(511 * 4), 32'hE000_0001);
    bus_write(12'h000, 32'hE000_0002);
    bus_write(12'h004, 32'hE000_0003);
    busy_mode = 1; cap_n = 0;
    bus_write(12'h800, 32'd16);
    bus_write(12'h804, 32'd510);
    bus_write(12'h808, 32'd0);
    wait_done("R8 wrapped configure completes");
    chk("R8 wrapped count", 32'(cap_n), 32'd4);
    for (int k = 0; k < 4; k++) chk("R8 wrapped word", cap[k], 32'hE000_0000 + k);
    busy_mode = 0;
  endtask

  task automatic t_abort;
    logic [31:0] d;
    rb_mode = 0;
    bus_write(12'h800, 32'd40);
    bus_write(12'h804, 32'd200);
    bus_write(12'h808, 32'd1);
    @(negedge clk);
    chk("R5 read request raised", {31'b0, cp_rd_req}, 32'h1);
    bus_write(12'h80C, 32'h0000_FEFE);
    chk("R10 read request dropped", {31'b0, cp_rd_req}, 32'h0);
    bus_read(12'h80C, d); chk("R10 done after abort", {31'b0, d[0]}, 32'h1);
    rb_mode = 1; rb_idx = 0;
    bus_write(12'h800, 32'd4);
    bus_write(12'h804, 32'd300);
    bus_write(12'h808, 32'd1);
    wait_done("R10 new transfer after abort");
    rb_mode = 0;
    bus_read(12'(300 * 4), d); chk("R10 transfer after abort stores", d, 32'hA000_0000);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_buffer();
    t_regs();
    t_config_busy();
    t_config_rate();
    t_readback();
    t_zero();
    t_wrap();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule